// File: doc/BRIEF.md
# Fractional-Rate Clock Enable with Kick-Applied Rate Update

This block produces a clock-enable pulse stream in the domain of a parent clock. Within every window of 32 parent cycles it passes exactly M cycles, where M = 32 − F and F is a 5-bit rate field. F = 0 gives an enable on every cycle. F = 31 gives one enable per window. A consumer gates its register updates with the enable and so runs at parent × M / 32.

Software reaches the block through a small word-wide register port. It stages a new F in the rate register and then sets a kick bit in a separate register. The hardware holds the running rate until the current 32-cycle window finishes. At that point it loads the staged value and clears the kick bit. The kick bit doubles as a busy flag. While it is set, further writes to the rate field are dropped.

A third register reports the rate that is currently in force. Inside a window the enables are spread by a modulo-32 accumulator, so no two pulses bunch together.

Top module: `cke_frac`

## Requirements
- R1: After reset the staged field reads 0, the kick bit reads 0, the status register reports field 0, and the enable is asserted on every cycle (full rate).
- R2: The rate register sits at address 0 and holds the field in bits 12:8. Every other bit reads 0, and writes to other bits are discarded.
- R3: With active field F, any 32 consecutive cycles in steady state carry exactly 32 − F enable pulses. This holds from F = 0 (32 pulses) to F = 31 (1 pulse).
- R4: Writing the rate register alone does not change the enable stream or the status register.
- R5: The kick register sits at address 1. Writing a word with bit 31 set makes bit 31 read as 1 and raises the `busy` output. Every other bit reads 0.
- R6: A pending kick is applied at the end of the current 32-cycle window and clears itself within 32 cycles. From the next cycle onward, every 32-cycle window runs wholly at the new rate.
- R7: A write to the rate register while the kick is pending is ignored, and the staged value is kept.
- R8: For multiplier M, the distance between successive enable pulses is always floor(32/M) or ceil(32/M) cycles.
- R9: The status register sits at address 2 and reports the active field in bits 12:8.
- R10: Writing the kick register with bit 31 clear has no effect: no kick is started and the rate stays the same.
- R11: Register reads return data on the clock edge after the address is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Parent clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address (0 rate, 1 kick, 2 status) |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Registered read data for the address of the previous cycle |
| clk_en | output | 1 | Registered clock-enable pulse stream |
| busy | output | 1 | Kick pending; mirrors kick bit 31 |

## Verification
The assertions assume that a raised kick comes only from a kick-register write with bit 31 set. They also assume that the register port carries at most one write per cycle, with addresses that stay stable while the strobe is high. The bench drives every bus access on the falling edge and holds it for exactly one rising edge. Between rate changes it waits for `busy` to clear, as a well-behaved driver would. The one exception is the deliberate write during a pending kick, which is meant to show that the write is dropped.

// File: rtl/cke_pkg.sv
package cke_pkg;
  localparam int ADDR_W = 2;
  typedef enum logic [ADDR_W-1:0] {
    A_RATE = 2'd0,
    A_KICK = 2'd1,
    A_STAT = 2'd2
  } reg_addr_e;
endpackage

// File: rtl/cke_regs.sv
module cke_regs
  import cke_pkg::*;
#(
  parameter int FRAC_W    = 5,
  parameter int DATA_W    = 32,
  parameter int FIELD_LSB = 8,
  parameter int KICK_BIT  = 31
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              apply,
  input  logic [FRAC_W-1:0] act_field,
  output logic [FRAC_W-1:0] stage_q,
  output logic              kick_q,
  output logic [DATA_W-1:0] rdata_q
);
  logic wr_rate, wr_kick;
  logic [DATA_W-1:0] rd_n;

  assign wr_rate = wr && (addr == A_RATE);
  assign wr_kick = wr && (addr == A_KICK) && wdata[KICK_BIT];

  // staged field: writes dropped while a kick is pending
  always_ff @(posedge clk) begin
    if (rst)                    stage_q <= '0;
    else if (wr_rate && !kick_q) stage_q <= wdata[FIELD_LSB +: FRAC_W];
  end

  // kick: completion has priority over a new request
  always_ff @(posedge clk) begin
    if (rst)          kick_q <= 1'b0;
    else if (apply)   kick_q <= 1'b0;
    else if (wr_kick) kick_q <= 1'b1;
  end

  always_comb begin
    rd_n = '0;
    case (addr)
      A_RATE:  rd_n[FIELD_LSB +: FRAC_W] = stage_q;
      A_KICK:  rd_n[KICK_BIT] = kick_q;
      A_STAT:  rd_n[FIELD_LSB +: FRAC_W] = act_field;
      default: rd_n = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) rdata_q <= '0;
    else     rdata_q <= rd_n;
  end
endmodule

// File: rtl/cke_window.sv
module cke_window #(
  parameter int FRAC_W = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              kick,
  input  logic [FRAC_W-1:0] stage_field,
  output logic [FRAC_W-1:0] phase_q,
  output logic              apply,
  output logic [FRAC_W:0]   mul_q,
  output logic [FRAC_W-1:0] act_field
);
  localparam int MUL_W = FRAC_W + 1;
  localparam int WIN   = 1 << FRAC_W;
  localparam logic [FRAC_W-1:0] LAST = FRAC_W'(WIN - 1);

  logic [MUL_W-1:0] diff;

  assign apply     = kick && (phase_q == LAST);
  assign diff      = MUL_W'(WIN) - mul_q;
  assign act_field = diff[FRAC_W-1:0];

  always_ff @(posedge clk) begin
    if (rst) phase_q <= '0;
    else     phase_q <= phase_q + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst)        mul_q <= MUL_W'(WIN);
    else if (apply) mul_q <= MUL_W'(WIN) - MUL_W'(stage_field);
  end
endmodule

// File: rtl/cke_accum.sv
module cke_accum #(
  parameter int FRAC_W = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [FRAC_W:0]   mul,
  output logic [FRAC_W-1:0] acc_q,
  output logic              pulse_q
);
  localparam int SUM_W = FRAC_W + 2;
  localparam int WIN   = 1 << FRAC_W;

  logic [SUM_W-1:0] sum, left;
  logic             wrap;

  assign sum  = SUM_W'(acc_q) + SUM_W'(mul);
  assign wrap = sum >= SUM_W'(WIN);
  assign left = wrap ? sum - SUM_W'(WIN) : sum;

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_q   <= '0;
      pulse_q <= 1'b0;
    end else begin
      acc_q   <= left[FRAC_W-1:0];
      pulse_q <= wrap;
    end
  end
endmodule

// File: rtl/cke_frac.sv
module cke_frac
  import cke_pkg::*;
#(
  parameter int FRAC_W    = 5,
  parameter int DATA_W    = 32,
  parameter int FIELD_LSB = 8,
  parameter int KICK_BIT  = 31
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr,
  input  logic [1:0]        reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              clk_en,
  output logic              busy
);
  logic [FRAC_W-1:0] stage_w, phase_w, act_w, acc_w;
  logic [FRAC_W:0]   mul_w;
  logic              kick_w, apply_w;

  cke_regs #(.FRAC_W(FRAC_W), .DATA_W(DATA_W), .FIELD_LSB(FIELD_LSB),
             .KICK_BIT(KICK_BIT)) u_regs (
    .clk(clk), .rst(rst), .wr(reg_wr), .addr(reg_addr), .wdata(reg_wdata),
    .apply(apply_w), .act_field(act_w), .stage_q(stage_w), .kick_q(kick_w),
    .rdata_q(reg_rdata)
  );

  cke_window #(.FRAC_W(FRAC_W)) u_win (
    .clk(clk), .rst(rst), .kick(kick_w), .stage_field(stage_w),
    .phase_q(phase_w), .apply(apply_w), .mul_q(mul_w), .act_field(act_w)
  );

  cke_accum #(.FRAC_W(FRAC_W)) u_acc (
    .clk(clk), .rst(rst), .mul(mul_w), .acc_q(acc_w), .pulse_q(clk_en)
  );

  assign busy = kick_w;
endmodule

// File: rtl/cke_frac_chk.sv
module cke_frac_chk #(
  parameter int FRAC_W   = 5,
  parameter int DATA_W   = 32,
  parameter int KICK_BIT = 31
) (
  input logic              clk,
  input logic              rst,
  input logic              reg_wr,
  input logic [1:0]        reg_addr,
  input logic [DATA_W-1:0] reg_wdata,
  input logic              busy,
  input logic [FRAC_W-1:0] phase,
  input logic [FRAC_W-1:0] acc,
  input logic [FRAC_W-1:0] stage,
  input logic [FRAC_W:0]   mul
);
  localparam int WIN = 1 << FRAC_W;

  // R6: a kick completes only at the last cycle of a window
  p_clear_at_window_end_r6: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> $past(phase) == FRAC_W'(WIN - 1));

  // R6: every window starts with an empty accumulator, so no window mixes rates
  p_window_aligned_r6: assert property (@(posedge clk) disable iff (rst)
    (phase == '0) |-> (acc == '0));

  // R7: rate writes during a pending kick leave the staged value alone
  p_drop_busy_write_r7: assert property (@(posedge clk) disable iff (rst)
    (busy && reg_wr && reg_addr == 2'd0) |=> $stable(stage));

  // R4: the running multiplier changes only when a kick is applied
  p_hold_rate_r4: assert property (@(posedge clk) disable iff (rst)
    !(busy && phase == FRAC_W'(WIN - 1)) |=> $stable(mul));

  // R5, R10: busy rises only after a kick write with the kick bit set
  p_kick_source_r5: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(reg_wr && reg_addr == 2'd1 && reg_wdata[KICK_BIT]));

  // R3: the multiplier stays within 1..WIN
  always @(posedge clk)
    if (!rst) p_mul_range_r3: assert (mul >= 1 && mul <= (FRAC_W+1)'(WIN));
endmodule

bind cke_frac cke_frac_chk #(.FRAC_W(FRAC_W), .DATA_W(DATA_W), .KICK_BIT(KICK_BIT)) u_chk (
  .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
  .reg_wdata(reg_wdata), .busy(busy), .phase(phase_w), .acc(acc_w),
  .stage(stage_w), .mul(mul_w)
);

// File: tb/sim_cke_frac.sv
`timescale 1ns/1ps
module sim_cke_frac;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_wr = 1'b0;
  logic [1:0]  reg_addr = 2'd0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        clk_en, busy;

  int n_run = 0, n_fail = 0;
  bit done = 1'b0;
  int cur_field = 0;

  always #2 clk = ~clk;

  cke_frac u0 (.clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
               .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
               .clk_en(clk_en), .busy(busy));

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    step();
    reg_wr = 1'b0; reg_wdata = '0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    reg_addr = a;
    step();   // R11: data valid after one edge
    d = reg_rdata;
  endtask

  task automatic count32(output int n);
    n = 0;
    for (int i = 0; i < 32; i++) begin
      step();
      if (clk_en) n++;
    end
  endtask

  task automatic wait_idle(output int cyc);
    cyc = 0;
    while (busy && cyc < 64) begin step(); cyc++; end
    step();   // first cycle computed at the new rate
  endtask

  task automatic t_reset();
    logic [31:0] d; int n;
    rd(2'd0, d); chk(d == 0, "R1 rate after reset", d, 0);
    rd(2'd1, d); chk(d == 0, "R1 kick after reset", d, 0);
    rd(2'd2, d); chk(d == 0, "R1 status after reset", d, 0);
    chk(busy == 0, "R1 busy after reset", busy, 0);
    count32(n); chk(n == 32, "R1 R3 full rate", n, 32);
  endtask

  task automatic t_regmap_staging();
    logic [31:0] d; int n;
    wr(2'd0, 32'hFFFF_FFFF);
    rd(2'd0, d); chk(d == 32'h0000_1F00, "R2 field bits 12:8", d, 32'h1F00);
    count32(n); chk(n == 32, "R4 staged write no output change", n, 32);
    rd(2'd2, d); chk(d == 0, "R4 R9 status unchanged", d, 0);
    chk(busy == 0, "R4 no kick", busy, 0);
  endtask

  task automatic t_change(input int f);
    logic [31:0] d; int n, cyc;
    wr(2'd0, 32'(f) << 8);
    wr(2'd1, 32'h8000_0000);
    chk(busy == 1, "R5 busy after kick", busy, 1);
    rd(2'd1, d); chk(d == 32'h8000_0000, "R5 kick reads 1", d, 32'h8000_0000);
    wait_idle(cyc);
    chk(cyc <= 32, "R6 kick clears in window", cyc, 32);
    count32(n); chk(n == 32 - f, "R3 R6 pulses per window", n, 32 - f);
    rd(2'd2, d); chk(d == 32'(f) << 8, "R9 status active field", d, 32'(f) << 8);
    cur_field = f;
  endtask

  task automatic t_ignore_busy();
    logic [31:0] d; int n, cyc;
    wr(2'd0, 32'(10) << 8);
    wr(2'd1, 32'h8000_0000);
    wr(2'd0, 32'(3) << 8);   // lands while kick still pending
    rd(2'd0, d); chk(d == 32'(10) << 8, "R7 staged value kept", d, 32'(10) << 8);
    wait_idle(cyc);
    count32(n); chk(n == 22, "R7 old staged rate applied", n, 22);
    cur_field = 10;
  endtask

  task automatic t_kick_zero();
    logic [31:0] d; int n; bit seen = 0;
    wr(2'd0, 32'(4) << 8);
    wr(2'd1, 32'h7FFF_FFFF);
    for (int i = 0; i < 40; i++) begin step(); if (busy) seen = 1; end
    chk(seen == 0, "R10 no kick started", seen, 0);
    count32(n); chk(n == 32 - cur_field, "R10 rate unchanged", n, 32 - cur_field);
    rd(2'd1, d); chk(d == 0, "R5 R10 kick reads 0", d, 0);
  endtask

  task automatic t_spread(input int f);
    int m, lo, hi, last, bad, cyc;
    m = 32 - f; lo = 32 / m; hi = (32 + m - 1) / m;
    wr(2'd0, 32'(f) << 8);
    wr(2'd1, 32'h8000_0000);
    wait_idle(cyc);
    last = -1; bad = 0;
    for (int i = 0; i < 96; i++) begin
      step();
      if (clk_en) begin
        if (last >= 0 && (i - last < lo || i - last > hi)) bad = i - last;
        last = i;
      end
    end
    chk(bad == 0, "R8 pulse gap", bad, lo);
    cur_field = f;
  endtask

  initial begin
    repeat (4) step();
    rst = 1'b0;
    t_reset();
    t_regmap_staging();
    t_change(31);
    t_change(16);
    t_change(1);
    t_change(0);
    t_ignore_busy();
    t_kick_zero();
    t_spread(29);
    t_spread(27);
    t_spread(20);
    t_spread(7);
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule